// File: doc/BRIEF.md
# Bitplane to Pixel Index Assembler

This block turns separately stored bitplanes back into per-pixel colour indices for a display pipeline. Each plane holds one bit of every pixel, and the planes live in separate regions rather than being interleaved, so a fetch unit delivers one byte per plane for the same group of eight horizontal pixels. The assembler stages those bytes as they arrive, moves a complete group into a bank of shift registers, and on every pixel-clock enable emits one colour index built from one bit of each plane.

Plane k always supplies bit k of the index. Within each plane byte the leftmost pixel of the group sits in the most significant bit, so the group is emitted from the MSB towards the LSB. A configurable active-plane count sets how many planes take part; the rest read as zero and need no data. When the next group is not complete by the time the shifters run dry, the output valid flag drops and the index reads zero until data arrives.

Top module: `bitplaneAssembler`

## Requirements
- R1: A synchronous reset clears the staged bytes, the shifters and the pixel counter, and drives `pixIndex` to 0 and `pixValid` to 0.
- R2: Plane k supplies bit k of `pixIndex`; plane k's byte is `planeData[8k+7:8k]`. Example: first-pixel bits of 1,0,1,0,1,1,0,0 on planes 7 down to 0 give index 0xAC.
- R3: Pixel j of a group (j = 0 is leftmost) is taken from bit 7−j of every plane byte, so the MSB is emitted first and the LSB last.
- R4: A plane whose number is at or above `activePlanes` contributes 0 to the index; any count of 8 or more enables all planes, and a count of 0 yields valid all-zero pixels with no loads.
- R5: A pulse on `planeLoad[k]` stages plane k's byte; a group is complete once every active plane has been staged since the last transfer, in any order and in any cycles, and a later pulse on the same plane replaces its staged byte.
- R6: A complete group moves into the shifters when they are empty, or in the same cycle as the enable that emits their last pixel, so groups flow back to back with no gap when the enable is high every cycle.
- R7: Each `pixEn` while pixels remain registers the next index with `pixValid` = 1 one clock after the enable; with `pixEn` low the outputs hold.
- R8: A `pixEn` that finds the shifters empty registers `pixValid` = 0 and `pixIndex` = 0; a group completing in that cycle transfers then and is emitted from the next enable.
- R9: Bytes staged while a group is shifting do not disturb the indices of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-clock enable; one pixel per high cycle |
| planeLoad | input | NUM_PLANES | Per-plane strobe staging that plane's byte |
| planeData | input | NUM_PLANES*PIX_PER_GROUP | Plane bytes, plane k in bits 8k+7..8k |
| activePlanes | input | $clog2(NUM_PLANES+1) | Number of planes taking part |
| pixIndex | output | NUM_PLANES | Assembled colour index |
| pixValid | output | 1 | Index valid flag |

## Verification
The bench builds the block with its defaults, eight planes and eight pixels per group, so the four-bit active-plane count reaches every value from 0 through 15, including the counts above eight that must act as all planes. Directed cases pin the 0xAC example, the MSB-first order, staggered staging and the gapless hand-over at the last pixel; random enables, loads and plane counts then drive underruns, reloads during shifting and mid-stream changes of the plane count.

// File: rtl/bpaPkg.sv
package bpaPkg;
  // Strobes from the control to the datapath, valid in the current cycle.
  typedef struct packed {
    logic transfer;  // copy staged bytes into the shifters
    logic shift;     // advance the shifters by one pixel
    logic emit;      // register the gathered index as valid
    logic starve;    // register an invalid, zero index
  } bpaCtl_t;
endpackage

// File: rtl/bpaLane.sv
module bpaLane #(
  parameter int PIX_PER_GROUP = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadByte,
  input  logic [PIX_PER_GROUP-1:0] byteIn,
  input  logic                     transfer,
  input  logic                     shift,
  output logic                     msbOut
);
  logic [PIX_PER_GROUP-1:0] stageByte;
  logic [PIX_PER_GROUP-1:0] shiftByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageByte <= '0;
    end else if (loadByte) begin
      stageByte <= byteIn;
    end
  end

  // Transfer wins over shift: the last pixel is read before the edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftByte <= '0;
    end else if (transfer) begin
      shiftByte <= stageByte;
    end else if (shift) begin
      shiftByte <= {shiftByte[PIX_PER_GROUP-2:0], 1'b0};
    end
  end

  assign msbOut = shiftByte[PIX_PER_GROUP-1];

  // R9: a transfer loads exactly what was staged before that edge
  a_r9_transfer_copies_stage: assert property (@(posedge clk) disable iff (rst)
    transfer |=> shiftByte == $past(stageByte));
endmodule

// File: rtl/bpaControl.sv
module bpaControl
  import bpaPkg::*;
#(
  parameter int NUM_PLANES    = 8,
  parameter int PIX_PER_GROUP = 8,
  localparam int ACT_W        = $clog2(NUM_PLANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pixEn,
  input  logic [NUM_PLANES-1:0] planeLoad,
  input  logic [ACT_W-1:0]      activePlanes,
  output bpaCtl_t               ctl,
  output logic [NUM_PLANES-1:0] planeMask
);
  localparam int CNT_W = $clog2(PIX_PER_GROUP + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PIX_PER_GROUP);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0]      pixLeft;
  logic [NUM_PLANES-1:0] pending;
  logic                  groupReady;
  logic                  shEmpty;
  logic                  shLast;

  for (genvar k = 0; k < NUM_PLANES; k++) begin : gMask
    assign planeMask[k] = (activePlanes > ACT_W'(k));
  end

  assign groupReady = &(pending | ~planeMask);
  assign shEmpty    = (pixLeft == '0);
  assign shLast     = (pixLeft == ONE_CNT);

  always_comb begin
    ctl.emit     = pixEn & ~shEmpty;
    ctl.shift    = pixEn & ~shEmpty;
    ctl.starve   = pixEn & shEmpty;
    ctl.transfer = groupReady & (shEmpty | (shLast & pixEn));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixLeft <= '0;
    end else if (ctl.transfer) begin
      pixLeft <= FULL_CNT;
    end else if (ctl.shift) begin
      pixLeft <= pixLeft - ONE_CNT;
    end
  end

  // A fresh load in the transfer cycle belongs to the next group.
  for (genvar k = 0; k < NUM_PLANES; k++) begin : gPend
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[k] <= 1'b0;
      end else if (planeLoad[k]) begin
        pending[k] <= 1'b1;
      end else if (ctl.transfer) begin
        pending[k] <= 1'b0;
      end
    end
  end

  // R6: counter never exceeds one group
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
    pixLeft <= FULL_CNT);

  // R6: a transfer only happens into empty or emptying shifters
  a_r6_transfer_when_free: assert property (@(posedge clk) disable iff (rst)
    ctl.transfer |-> (pixLeft == '0) || (pixLeft == ONE_CNT && pixEn));

  // R6: after a transfer a full group is waiting
  a_r6_transfer_refills: assert property (@(posedge clk) disable iff (rst)
    ctl.transfer |=> pixLeft == FULL_CNT);

  // R5: a group only moves when all active planes are staged
  a_r5_transfer_needs_all: assert property (@(posedge clk) disable iff (rst)
    ctl.transfer |-> ((pending | ~planeMask) == '1));

  // R1: after reset nothing is waiting in the shifters
  a_r1_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> pixLeft == '0);
endmodule

// File: rtl/bpaDatapath.sv
module bpaDatapath
  import bpaPkg::*;
#(
  parameter int NUM_PLANES    = 8,
  parameter int PIX_PER_GROUP = 8,
  localparam int DATA_W       = NUM_PLANES * PIX_PER_GROUP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bpaCtl_t               ctl,
  input  logic [NUM_PLANES-1:0] planeMask,
  input  logic [NUM_PLANES-1:0] planeLoad,
  input  logic [DATA_W-1:0]     planeData,
  input  logic                  pixEn,
  output logic [NUM_PLANES-1:0] pixIndex,
  output logic                  pixValid
);
  logic [NUM_PLANES-1:0] laneMsb;

  for (genvar k = 0; k < NUM_PLANES; k++) begin : gLane
    bpaLane #(.PIX_PER_GROUP(PIX_PER_GROUP)) uLane (
      .clk      (clk),
      .rst      (rst),
      .loadByte (planeLoad[k]),
      .byteIn   (planeData[k*PIX_PER_GROUP +: PIX_PER_GROUP]),
      .transfer (ctl.transfer),
      .shift    (ctl.shift),
      .msbOut   (laneMsb[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixIndex <= '0;
      pixValid <= 1'b0;
    end else if (ctl.emit) begin
      pixIndex <= laneMsb & planeMask;
      pixValid <= 1'b1;
    end else if (ctl.starve) begin
      pixIndex <= '0;
      pixValid <= 1'b0;
    end
  end

  // R4: inactive planes never reach the index
  a_r4_inactive_zero: assert property (@(posedge clk) disable iff (rst)
    ctl.emit |=> (pixIndex & ~$past(planeMask)) == '0);

  // R7: without an enable the outputs hold
  a_r7_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(pixIndex) && $stable(pixValid));

  // R8: an underrun clears valid and index
  a_r8_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    ctl.starve |=> !pixValid && pixIndex == '0);

  // R8: an invalid output always carries a zero index
  a_r8_invalid_is_zero: assert property (@(posedge clk) disable iff (rst)
    !pixValid |-> pixIndex == '0);

  // R7: emit and starve are exclusive
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.emit, ctl.starve}));
endmodule

// File: rtl/bitplaneAssembler.sv
module bitplaneAssembler
  import bpaPkg::*;
#(
  parameter int NUM_PLANES    = 8,
  parameter int PIX_PER_GROUP = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                pixEn,
  input  logic [NUM_PLANES-1:0]               planeLoad,
  input  logic [NUM_PLANES*PIX_PER_GROUP-1:0] planeData,
  input  logic [$clog2(NUM_PLANES+1)-1:0]     activePlanes,
  output logic [NUM_PLANES-1:0]               pixIndex,
  output logic                                pixValid
);
  bpaCtl_t               ctl;
  logic [NUM_PLANES-1:0] planeMask;

  bpaControl #(
    .NUM_PLANES    (NUM_PLANES),
    .PIX_PER_GROUP (PIX_PER_GROUP)
  ) uCtl (
    .clk          (clk),
    .rst          (rst),
    .pixEn        (pixEn),
    .planeLoad    (planeLoad),
    .activePlanes (activePlanes),
    .ctl          (ctl),
    .planeMask    (planeMask)
  );

  bpaDatapath #(
    .NUM_PLANES    (NUM_PLANES),
    .PIX_PER_GROUP (PIX_PER_GROUP)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .planeMask (planeMask),
    .planeLoad (planeLoad),
    .planeData (planeData),
    .pixEn     (pixEn),
    .pixIndex  (pixIndex),
    .pixValid  (pixValid)
  );

  // R1: outputs are cleared on the edge after reset
  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> !pixValid && pixIndex == '0);
endmodule

// File: tb/tb_bitplaneAssembler.sv
`timescale 1ns/1ps
module tb_bitplaneAssembler;
  localparam int NP = 8;
  localparam int PG = 8;
  localparam int AW = $clog2(NP + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              pixEn;
  logic [NP-1:0]     planeLoad;
  logic [NP*PG-1:0]  planeData;
  logic [AW-1:0]     activePlanes;
  logic [NP-1:0]     pixIndex;
  logic              pixValid;

  always #2.5 clk = ~clk;

  bitplaneAssembler #(.NUM_PLANES(NP), .PIX_PER_GROUP(PG)) dut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .planeLoad(planeLoad),
    .planeData(planeData), .activePlanes(activePlanes),
    .pixIndex(pixIndex), .pixValid(pixValid)
  );

  // Reference state built from the requirements
  logic [PG-1:0] mStage [NP];
  logic [PG-1:0] mShift [NP];
  logic [NP-1:0] mPend;
  int            mCnt;
  logic [NP-1:0] mIdx;
  logic          mValid;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  function automatic logic [NP-1:0] maskOf(input logic [AW-1:0] a);
    logic [NP-1:0] m;
    for (int k = 0; k < NP; k++) m[k] = (int'(a) > k);
    return m;
  endfunction

  // Byte set whose pixel 0 forms index v on all planes
  function automatic logic [NP*PG-1:0] firstPixel(input logic [NP-1:0] v,
                                                  input logic [NP*PG-1:0] rest);
    logic [NP*PG-1:0] d = rest;
    for (int k = 0; k < NP; k++) d[k*PG + PG-1] = v[k];
    return d;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < NP; k++) begin mStage[k] = '0; mShift[k] = '0; end
    mPend = '0; mCnt = 0; mIdx = '0; mValid = 1'b0;
  endtask

  task automatic modelStep();
    logic [NP-1:0] m = maskOf(activePlanes);
    bit rdy   = ((mPend | ~m) == '1);
    bit emit  = pixEn && (mCnt > 0);
    bit stv   = pixEn && (mCnt == 0);
    bit xfer  = rdy && (mCnt == 0 || (mCnt == 1 && pixEn));
    if (emit) begin
      for (int k = 0; k < NP; k++) mIdx[k] = mShift[k][PG-1] & m[k];
      mValid = 1'b1;
    end else if (stv) begin
      mIdx = '0; mValid = 1'b0;
    end
    for (int k = 0; k < NP; k++) begin
      if (xfer) mShift[k] = mStage[k];
      else if (emit) mShift[k] = mShift[k] << 1;
    end
    if (xfer) mCnt = PG; else if (emit) mCnt = mCnt - 1;
    for (int k = 0; k < NP; k++) begin
      if (planeLoad[k]) begin mStage[k] = planeData[k*PG +: PG]; mPend[k] = 1'b1; end
      else if (xfer) mPend[k] = 1'b0;
    end
  endtask

  task automatic checkLit(input string tag, input logic [NP-1:0] eIdx, input logic eVal);
    checks++;
    if (pixIndex !== eIdx || pixValid !== eVal) begin
      fails++;
      $display("FAIL %s: index=%02h valid=%0b expected index=%02h valid=%0b",
               tag, pixIndex, pixValid, eIdx, eVal);
    end
  endtask

  // Drive one cycle from a falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic tick(input logic en, input logic [NP-1:0] ld,
                      input logic [NP*PG-1:0] d, input string tag);
    pixEn = en; planeLoad = ld; planeData = d;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkLit(tag, mIdx, mValid);
  endtask

  task automatic resetDut();
    pixEn = 1'b0; planeLoad = '0; planeData = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  function automatic logic [NP*PG-1:0] rndData();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd4711));
    activePlanes = AW'(NP);
    resetDut();

    // R1: cleared outputs, and no group is waiting
    checkLit("R1 reset outputs", 8'h00, 1'b0);
    tick(1'b1, '0, '0, "R1 first enable after reset");
    checkLit("R1 no group after reset", 8'h00, 1'b0);

    // R2: 0xAC example on the first pixel
    resetDut();
    tick(1'b0, '1, firstPixel(8'hAC, rndData()), "R2 load");
    tick(1'b0, '0, '0, "R2 transfer");
    tick(1'b1, '0, '0, "R2 first pixel");
    checkLit("R2 example 0xAC", 8'hAC, 1'b1);

    // R3: MSB first, one plane active
    resetDut();
    activePlanes = AW'(1);
    tick(1'b0, 8'h01, {56'hFFFF_FFFF_FFFF_FF, 8'h96}, "R3 load");
    tick(1'b0, '0, '0, "R3 transfer");
    for (int j = 0; j < PG; j++) begin
      logic [7:0] pat = 8'h96;
      tick(1'b1, '0, '0, "R3 order");
      checkLit("R3 bit 7-j order", {7'b0, pat[PG-1-j]}, 1'b1);
    end

    // R4: partial, zero and oversized plane counts
    resetDut();
    activePlanes = AW'(3);
    tick(1'b0, 8'h07, '1, "R4 load three");
    tick(1'b0, '0, '0, "R4 transfer");
    tick(1'b1, '0, '0, "R4 pixel");
    checkLit("R4 three planes", 8'h07, 1'b1);
    resetDut();
    activePlanes = '0;
    tick(1'b0, '0, '0, "R4 zero transfer");
    tick(1'b1, '0, '0, "R4 zero pixel");
    checkLit("R4 zero planes valid", 8'h00, 1'b1);
    resetDut();
    activePlanes = AW'(12);
    tick(1'b0, '1, '1, "R4 load all");
    tick(1'b0, '0, '0, "R4 transfer all");
    tick(1'b1, '0, '0, "R4 pixel all");
    checkLit("R4 count above planes", 8'hFF, 1'b1);

    // R5 / R8: staggered staging with enables meanwhile
    resetDut();
    activePlanes = AW'(4);
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, NP'(1 << k), '1, "R5 staggered load");
      tick(1'b1, '0, '0, "R8 underrun while staging");
      if (k < 3) checkLit("R8 underrun invalid", 8'h00, 1'b0);
    end
    tick(1'b1, '0, '0, "R5 first after complete");
    checkLit("R5 group complete", 8'h0F, 1'b1);

    // R6 / R9: back-to-back groups, next group staged while shifting
    resetDut();
    activePlanes = AW'(NP);
    tick(1'b0, '1, firstPixel(8'h11, rndData()), "R6 load A");
    tick(1'b0, '0, '0, "R6 transfer A");
    for (int j = 0; j < 2 * PG; j++) begin
      tick(1'b1, (j == 2) ? '1 : '0,
           (j == 2) ? firstPixel(8'h5A, rndData()) : '0, "R9 shift with staging");
      checkLit("R6 no gap valid", pixIndex, 1'b1);
      if (j == 0) checkLit("R9 group A untouched", 8'h11, 1'b1);
      if (j == PG) checkLit("R6 group B follows", 8'h5A, 1'b1);
    end
    tick(1'b1, '0, '0, "R8 drained");
    checkLit("R8 after drain", 8'h00, 1'b0);

    // R7: outputs hold while the enable is low
    tick(1'b0, '1, '1, "R7 load");
    tick(1'b0, '0, '0, "R7 transfer");
    tick(1'b1, '0, '0, "R7 pixel");
    for (int j = 0; j < 4; j++) begin
      tick(1'b0, '0, '0, "R7 hold");
      checkLit("R7 hold", 8'hFF, 1'b1);
    end

    // Random traffic against the reference model
    resetDut();
    for (int c = 0; c < 4000; c++) begin
      logic [NP-1:0] ld = '0;
      if (($urandom() % 150) == 0) activePlanes = AW'($urandom() % 16);
      for (int k = 0; k < NP; k++) ld[k] = (($urandom() % 6) == 0);
      tick((($urandom() % 10) < 7), ld, rndData(), "R7 random stream");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: index=%02h valid=%0b expected index=-- valid=-", pixIndex, pixValid);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule